// File: doc/BRIEF.md
# CAN Controller Mode Sequencer

This block steps a CAN controller between its sleep, initialization and normal operating modes. Software drives two level request bits, one for initialization and one for sleep, and polls two acknowledge bits to learn when a mode change has finished. Normal mode is not entered as soon as both requests drop. The block first passes through a bus-synchronization phase. It leaves that phase only after it has seen a run of consecutive recessive bits on the sampled receive line, counted on a bit-time strobe.

While the controller is asleep, an optional automatic wake-up returns it to synchronization when a dominant start-of-frame bit appears. This also raises a wake-up flag. The automatic wake-up masks the still-asserted sleep request until software releases that request. A soft-reset input forces the controller back to sleep. Separate sleep-entered and wake-up flags stay set until software clears them with a one-cycle clear pulse.

Top module: `can_mode_seq`

## Requirements
- R1: After reset the mode output is 0 (sleep), sleep_ack is 1, init_ack is 0, and both interrupt flags are 0.
- R2: With init_req=1 and no soft reset, the next clock edge gives mode 1 (init), init_ack=1 and sleep_ack=0, whatever the current mode.
- R3: When init_req and sleep_req are both 1, the initialization request wins and the mode becomes 1.
- R4: With sleep_req=1, init_req=0 and no wake-up mask, the next edge gives mode 0 with sleep_ack=1 and init_ack=0. If the mode was not already 0, sleep_flag is set.
- R5: With both requests at 0, sleep or init moves to mode 2 (synchronizing) on the next edge. The acknowledge bit of the mode it came from stays at 1 during this phase. Mode 3 (normal), with both acks at 0, is reached on the edge that samples the SYNC_BITS-th (default 11) consecutive recessive bit (rx_bit=1 while bit_tick=1). Cycles without bit_tick do not count.
- R6: A dominant bit (rx_bit=0 with bit_tick=1) during synchronization restarts the recessive count from zero.
- R7: When asleep with auto_wake=1, a dominant bit sampled on bit_tick moves the mode to 2 and sets wake_flag on the next edge. From then on sleep_req is ignored until it has been seen at 0.
- R8: With auto_wake=0, a dominant bit while asleep leaves the mode at 0 and wake_flag at 0.
- R9: A software wake-up (clearing sleep_req while asleep) moves to mode 2 without setting wake_flag.
- R10: soft_reset=1 forces mode 0 on the next edge, overriding both requests, and sets sleep_flag if the mode was not already 0.
- R11: A 1 on clr_sleep or clr_wake clears the matching flag on the next edge. If the flag is set in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Initialization request level |
| sleep_req | input | 1 | Sleep request level |
| auto_wake | input | 1 | Enables wake-up on bus activity |
| soft_reset | input | 1 | Forces a return to sleep |
| rx_bit | input | 1 | Sampled receive line, 1 = recessive |
| bit_tick | input | 1 | One-cycle strobe marking each bit sample |
| clr_sleep | input | 1 | Clears sleep_flag |
| clr_wake | input | 1 | Clears wake_flag |
| init_ack | output | 1 | Initialization acknowledge |
| sleep_ack | output | 1 | Sleep acknowledge |
| mode | output | 2 | 0 sleep, 1 init, 2 synchronizing, 3 normal |
| sleep_flag | output | 1 | Sleep-entered interrupt flag |
| wake_flag | output | 1 | Automatic wake-up interrupt flag |

## Verification
Every result is registered once, so a request, soft reset, clear pulse or sampled bit shows on mode, the acks and the flags at the first rising edge after the input is applied. The bench drives inputs on the falling edge and reads outputs one full cycle later, on the next falling edge. For synchronization the bench counts strobes rather than cycles: it checks that the mode is still 2 after SYNC_BITS-1 recessive strobes, and 3 right after the next one, for every position of a single dominant bit in the run.

// File: rtl/can_mode_seq.sv
module can_mode_seq #(
  parameter int SYNC_BITS = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_req,
  input  logic       sleep_req,
  input  logic       auto_wake,
  input  logic       soft_reset,
  input  logic       rx_bit,
  input  logic       bit_tick,
  input  logic       clr_sleep,
  input  logic       clr_wake,
  output logic       init_ack,
  output logic       sleep_ack,
  output logic [1:0] mode,
  output logic       sleep_flag,
  output logic       wake_flag
);

  localparam int CW = $clog2(SYNC_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(SYNC_BITS - 1);
  localparam logic [1:0] M_SLEEP = 2'd0, M_INIT = 2'd1, M_SYNC = 2'd2, M_NORM = 2'd3;

  logic [1:0]    st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic          from_sleep, from_sleep_nx;
  logic          hold, hold_nx;
  logic          wake_ev;

  assign wake_ev = (st == M_SLEEP) && auto_wake && bit_tick && !rx_bit && !soft_reset && !init_req;

  always_comb begin
    st_nx         = st;
    cnt_nx        = cnt;
    from_sleep_nx = from_sleep;
    if (soft_reset)
      st_nx = M_SLEEP;
    else if (init_req)
      st_nx = M_INIT;
    else if (wake_ev) begin
      st_nx         = M_SYNC;
      from_sleep_nx = 1'b1;
      cnt_nx        = '0;
    end else if (sleep_req && !hold)
      st_nx = M_SLEEP;
    else if (st == M_SLEEP || st == M_INIT) begin
      st_nx         = M_SYNC;
      from_sleep_nx = (st == M_SLEEP);
      cnt_nx        = '0;
    end else if (st == M_SYNC && bit_tick) begin
      if (!rx_bit)
        cnt_nx = '0;
      else if (cnt == LAST)
        st_nx = M_NORM;
      else
        cnt_nx = cnt + 1'b1;
    end
  end

  assign hold_nx = wake_ev | (hold & sleep_req & !soft_reset & !init_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= M_SLEEP;
      cnt        <= '0;
      from_sleep <= 1'b1;
      hold       <= 1'b0;
      sleep_flag <= 1'b0;
      wake_flag  <= 1'b0;
    end else begin
      st         <= st_nx;
      cnt        <= cnt_nx;
      from_sleep <= from_sleep_nx;
      hold       <= hold_nx;
      sleep_flag <= (st != M_SLEEP && st_nx == M_SLEEP) | (sleep_flag & !clr_sleep);
      wake_flag  <= wake_ev | (wake_flag & !clr_wake);
    end
  end

  assign mode      = st;
  assign sleep_ack = (st == M_SLEEP) || (st == M_SYNC && from_sleep);
  assign init_ack  = (st == M_INIT) || (st == M_SYNC && !from_sleep);

  AST_ACKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(init_ack && sleep_ack)) else $error("both acks set"); // R5

  AST_INIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req && !soft_reset) |=> (mode == M_INIT && init_ack && !sleep_ack)) else $error("init"); // R3

  AST_SOFT_RESET_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |=> (mode == M_SLEEP && sleep_ack && !init_ack)) else $error("soft reset"); // R10

  AST_NORMAL_AFTER_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_NORM) ##1 (mode == M_NORM) |-> ($past(bit_tick) && $past(rx_bit) && $past(mode) == M_SYNC))
    else $error("normal without recessive bit"); // R5

  AST_WAKE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> ($past(auto_wake) && $past(mode) == M_SLEEP && !$past(rx_bit)))
    else $error("spurious wake flag"); // R7

  AST_WAKE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wake && !(auto_wake && bit_tick && !rx_bit)) |=> !wake_flag) else $error("wake clear"); // R11

endmodule

// File: tb/test_can_mode_seq.sv
module test_can_mode_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic init_req = 0, sleep_req = 1, auto_wake = 0, soft_reset = 0;
  logic rx_bit = 1, bit_tick = 0, clr_sleep = 0, clr_wake = 0;
  logic init_ack, sleep_ack, sleep_flag, wake_flag;
  logic [1:0] mode;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  can_mode_seq #(.SYNC_BITS(11)) i_can_mode_seq (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .sleep_req(sleep_req),
    .auto_wake(auto_wake), .soft_reset(soft_reset), .rx_bit(rx_bit), .bit_tick(bit_tick),
    .clr_sleep(clr_sleep), .clr_wake(clr_wake), .init_ack(init_ack), .sleep_ack(sleep_ack),
    .mode(mode), .sleep_flag(sleep_flag), .wake_flag(wake_flag));

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic btick(input logic r);
    bit_tick = 1; rx_bit = r; tick();
    bit_tick = 0; rx_bit = 1; tick();
  endtask

  task automatic goto_mode(input int s);
    soft_reset = 1; init_req = 0; sleep_req = 1; auto_wake = 0; tick();
    soft_reset = 0;
    if (s == 1) begin sleep_req = 0; init_req = 1; tick(); end
    if (s >= 2) begin sleep_req = 0; init_req = 1; tick(); init_req = 0; tick(); end
    if (s == 3) repeat (11) btick(1);
    clr_sleep = 1; clr_wake = 1; tick(); clr_sleep = 0; clr_wake = 0;
  endtask

  initial begin
    #(4 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 mode", mode, 0); chk("R1 sleep_ack", sleep_ack, 1); chk("R1 init_ack", init_ack, 0);
    chk("R1 sleep_flag", sleep_flag, 0); chk("R1 wake_flag", wake_flag, 0);
    rst_n = 1; tick();
    chk("R1 mode held", mode, 0);

    // R2 R3 R4 R5: every start mode under every request pair
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 4; c++) begin
        int e;
        goto_mode(s);
        chk("R2 start mode", mode, s);
        init_req = c[1]; sleep_req = c[0]; tick();
        e = c[1] ? 1 : c[0] ? 0 : (s < 2) ? 2 : s;
        chk(c == 3 ? "R3 priority" : c == 2 ? "R2 init" : c == 1 ? "R4 sleep" : "R5 release", mode, e);
        if (e == 0) chk("R4 acks", {init_ack, sleep_ack}, 1);
        if (e == 1) chk("R2 acks", {init_ack, sleep_ack}, 2);
        if (e == 3) chk("R5 acks", {init_ack, sleep_ack}, 0);
        chk("R4 sleep_flag", sleep_flag, (s != 0 && e == 0) ? 1 : 0);
      end
    end

    // R5 R6: dominant bit at every position of the run
    for (int p = 0; p <= 10; p++) begin
      goto_mode(2);
      chk("R5 sync from init ack", {init_ack, sleep_ack}, 2);
      repeat (p) btick(1);
      btick(0);
      repeat (10) btick(1);
      chk("R6 restarted count", mode, 2);
      btick(1);
      chk("R6 normal after full run", mode, 3);
    end
    goto_mode(2);
    repeat (10) btick(1);
    repeat (5) tick();
    chk("R5 idle cycles do not count", mode, 2);
    btick(1);
    chk("R5 normal", mode, 3);

    // R8
    goto_mode(0);
    btick(0);
    chk("R8 mode", mode, 0); chk("R8 wake_flag", wake_flag, 0);

    // R7
    auto_wake = 1; bit_tick = 1; rx_bit = 0; tick(); bit_tick = 0; rx_bit = 1;
    chk("R7 mode", mode, 2); chk("R7 wake_flag", wake_flag, 1); chk("R7 sleep_ack", sleep_ack, 1);
    repeat (4) tick();
    chk("R7 sleep request masked", mode, 2);
    repeat (11) btick(1);
    chk("R7 normal", mode, 3);
    sleep_req = 0; tick(); sleep_req = 1; tick();
    chk("R7 mask released", mode, 0);

    // R11
    goto_mode(0);
    auto_wake = 1; bit_tick = 1; rx_bit = 0; clr_wake = 1; tick();
    bit_tick = 0; rx_bit = 1; clr_wake = 0;
    chk("R11 set wins", wake_flag, 1);
    clr_wake = 1; tick(); clr_wake = 0;
    chk("R11 wake clear", wake_flag, 0);
    soft_reset = 1; tick(); soft_reset = 0;
    chk("R10 flag from sync", sleep_flag, 1);
    clr_sleep = 1; tick(); clr_sleep = 0;
    chk("R11 sleep clear", sleep_flag, 0);

    // R9
    goto_mode(0);
    sleep_req = 0; tick();
    chk("R9 mode", mode, 2); chk("R9 wake_flag", wake_flag, 0);

    // R10
    goto_mode(3);
    init_req = 1; sleep_req = 0; soft_reset = 1; tick(); soft_reset = 0;
    chk("R10 mode", mode, 0); chk("R10 sleep_flag", sleep_flag, 1);
    chk("R10 acks", {init_ack, sleep_ack}, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule